// File: doc/BRIEF.md
# Keyboard and Mouse Controller Host Interface

This block is the host-facing register and command logic of a classic PC keyboard and mouse controller. A byte-wide bus reaches two ports. The data port carries bytes to and from the attached devices. The command/status port accepts controller commands and returns a status byte. An address counts as a command/status access when it has any bit of a configurable select mask set. Every other address is a data access.

The block holds a mode byte, a status byte and an output-port byte. It drives the A20 gate and a system reset request from the output port. It raises the keyboard and mouse interrupts, each gated by its enable bit in the mode byte. Each device has a single-byte holding slot. The host output register presents the keyboard slot first. It presents the mouse slot only when the keyboard slot is empty.

Pulse commands drive selected low output-port lines low for a fixed time. That time is set from the clock frequency. The serial links to the devices sit outside this block. Here they are byte-valid strobes in each direction.

Top module: `kbc_host_if`

## Requirements
- R1: An access whose address ANDed with CMD_SEL_MASK (default 0x04) is non-zero selects the command port on write and the status byte on read. Any other address selects the data port.
- R2: After reset, the status byte reads 0x18, the mode byte is 0x03 and the output port is 0x03. In that state a20_gate is 1, port_lines is 4'h3, and sys_reset_req, irq_kbd and irq_aux are 0.
- R3: A data write with no command waiting for data gives a one-cycle kbd_tx_valid pulse carrying that byte. After command 0xD4, the next data write goes to aux_tx instead. One data write consumes the waiting command. Any later command write cancels a waiting command, and an unrecognised command has no other effect.
- R4: Command 0x20 loads the mode byte into the keyboard slot. Command 0x60 makes the next data write load the mode byte. Mode bit 0 enables the keyboard interrupt and bit 1 enables the mouse interrupt.
- R5: Command 0xD0 loads the output-port view into the keyboard slot. The view is the stored byte with bit 4 replaced by "any slot full" and bit 5 replaced by "mouse slot alone full", both taken at command time. Command 0xD1 makes the next data write load the whole output port. Bit 1 drives a20_gate, and sys_reset_req is 1 while bit 0 is 0.
- R6: Command 0xDF sets output-port bit 1, so a20_gate goes high. Command 0xDD clears that bit, so a20_gate goes low.
- R7: A command byte 0xF0 to 0xFF is a pulse command. Each zero bit among its low four bits drives that port line low for CLK_MHZ*PULSE_US cycles, which is 1200 with the defaults. 0xFE pulses the reset line (sys_reset_req high) and 0xFF does nothing. A pulse command that arrives while a pulse is running is ignored.
- R8: A data-port read returns the keyboard slot if it is full, and otherwise the mouse slot. The read empties the slot it returned.
- R9: The status byte carries four live fields. Bit 0 is 1 when any slot is full. Bit 5 is 1 when the mouse slot alone is full. Bit 3 is 1 when the last port write went to the command port. Bit 4 is always 1. All other bits are 0.
- R10: irq_kbd is 1 while the keyboard slot is full and mode bit 0 is set. irq_aux is 1 while only the mouse slot is full and mode bit 1 is set.
- R11: A device byte is accepted only if its slot is empty after that cycle's read, and is otherwise dropped. A controller response (0x20, 0xD0) always loads the keyboard slot and wins over a keyboard byte arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address, decoded with CMD_SEL_MASK |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (status or host output register) |
| kbd_rx_valid | input | 1 | Keyboard byte arriving |
| kbd_rx_byte | input | 8 | Keyboard byte |
| aux_rx_valid | input | 1 | Mouse byte arriving |
| aux_rx_byte | input | 8 | Mouse byte |
| kbd_tx_valid | output | 1 | One-cycle strobe of a byte for the keyboard |
| kbd_tx_byte | output | 8 | Byte for the keyboard |
| aux_tx_valid | output | 1 | One-cycle strobe of a byte for the mouse |
| aux_tx_byte | output | 8 | Byte for the mouse |
| irq_kbd | output | 1 | Keyboard interrupt |
| irq_aux | output | 1 | Mouse interrupt |
| port_lines | output | 4 | Low output-port lines after pulsing |
| a20_gate | output | 1 | A20 gate line |
| sys_reset_req | output | 1 | System reset request, active high |

## Verification
Directed sequences run every command in turn, including the unknown command that cancels a waiting 0xD4 and the write-output-port values that clear bit 1 and then bit 0. The output-port read is taken with only the mouse slot full, which shows whether bits 4 and 5 are the live flags rather than stored bits. Pulse commands 0xFE, 0xFD, 0xF0 and 0xFF, plus a second pulse sent during a running one, separate the line selection, the pulse length and the ignore-while-busy rule. Random mixes of device bytes, reads, status reads and response commands against a bench model show the keyboard-first order, the drop-when-full rule and the interrupt gating.

// File: rtl/kbc_pkg.sv
`timescale 1ns/1ps
package kbc_pkg;

    // command bytes recognised on the command port
    localparam logic [7:0] CMD_RD_MODE = 8'h20;
    localparam logic [7:0] CMD_WR_MODE = 8'h60;
    localparam logic [7:0] CMD_RD_OUTP = 8'hD0;
    localparam logic [7:0] CMD_WR_OUTP = 8'hD1;
    localparam logic [7:0] CMD_WR_AUX  = 8'hD4;
    localparam logic [7:0] CMD_A20_OFF = 8'hDD;
    localparam logic [7:0] CMD_A20_ON  = 8'hDF;

    // what the next data-port write is meant for
    typedef enum logic [1:0] {
        WAIT_NONE = 2'd0,
        WAIT_MODE = 2'd1,
        WAIT_OUTP = 2'd2,
        WAIT_AUX  = 2'd3
    } wait_e;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_RD_MODE,
        ACT_WR_MODE,
        ACT_RD_OUTP,
        ACT_WR_OUTP,
        ACT_WR_AUX,
        ACT_A20_ON,
        ACT_A20_OFF,
        ACT_PULSE
    } act_e;

    typedef struct packed {
        logic [7:0] kbd_buf;
        logic [7:0] aux_buf;
        logic       kbd_full;
        logic       aux_full;
        logic [7:0] mode;
        logic [7:0] outp;
        wait_e      wt;
        logic       cmd_flag;
        logic       ktx_v;
        logic [7:0] ktx_b;
        logic       atx_v;
        logic [7:0] atx_b;
    } hst_t;

    localparam hst_t HST_RST = '{
        kbd_buf:  8'h00,
        aux_buf:  8'h00,
        kbd_full: 1'b0,
        aux_full: 1'b0,
        mode:     8'h03,
        outp:     8'h03,
        wt:       WAIT_NONE,
        cmd_flag: 1'b1,
        ktx_v:    1'b0,
        ktx_b:    8'h00,
        atx_v:    1'b0,
        atx_b:    8'h00
    };

endpackage

// File: rtl/kbc_cmd_dec.sv
`timescale 1ns/1ps
module kbc_cmd_dec
    import kbc_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output act_e       act,
    output logic [3:0] pulse_sel
);
    always_comb begin
        // zero bits in the low nibble select lines to pulse
        pulse_sel = ~cmd_byte[3:0];
        act       = ACT_NONE;
        if (cmd_byte[7:4] == 4'hF) begin
            act = ACT_PULSE;
        end else begin
            case (cmd_byte)
                CMD_RD_MODE: act = ACT_RD_MODE;
                CMD_WR_MODE: act = ACT_WR_MODE;
                CMD_RD_OUTP: act = ACT_RD_OUTP;
                CMD_WR_OUTP: act = ACT_WR_OUTP;
                CMD_WR_AUX:  act = ACT_WR_AUX;
                CMD_A20_ON:  act = ACT_A20_ON;
                CMD_A20_OFF: act = ACT_A20_OFF;
                default:     act = ACT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/kbc_pulse_gen.sv
`timescale 1ns/1ps
module kbc_pulse_gen #(
    parameter int unsigned CYCLES = 1200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] sel,
    output logic       busy,
    output logic [3:0] low
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [3:0]    sel;
    } pst_t;

    pst_t d, q;

    always_comb begin
        d = q;
        if (q.cnt != '0) begin
            d.cnt = q.cnt - CW'(1);
        end else if (start && (sel != 4'h0)) begin
            d.cnt = CW'(CYCLES);
            d.sel = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.cnt != '0);
    assign low  = busy ? q.sel : 4'h0;
endmodule

// File: rtl/kbc_out_sel.sv
`timescale 1ns/1ps
module kbc_out_sel (
    input  logic       kbd_full,
    input  logic       aux_full,
    input  logic [7:0] kbd_byte,
    input  logic [7:0] aux_byte,
    output logic [7:0] host_byte,
    output logic       any_full,
    output logic       aux_only
);
    always_comb begin
        // keyboard slot is served first
        host_byte = kbd_full ? kbd_byte : aux_byte;
        any_full  = kbd_full | aux_full;
        aux_only  = aux_full & ~kbd_full;
    end
endmodule

// File: rtl/kbc_host_if.sv
`timescale 1ns/1ps
module kbc_host_if
    import kbc_pkg::*;
#(
    parameter int unsigned           ADDR_W       = 8,
    parameter logic [ADDR_W-1:0]     CMD_SEL_MASK = ADDR_W'(4),
    parameter int unsigned           CLK_MHZ      = 200,
    parameter int unsigned           PULSE_US     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              kbd_rx_valid,
    input  logic [7:0]        kbd_rx_byte,
    input  logic              aux_rx_valid,
    input  logic [7:0]        aux_rx_byte,
    output logic              kbd_tx_valid,
    output logic [7:0]        kbd_tx_byte,
    output logic              aux_tx_valid,
    output logic [7:0]        aux_tx_byte,
    output logic              irq_kbd,
    output logic              irq_aux,
    output logic [3:0]        port_lines,
    output logic              a20_gate,
    output logic              sys_reset_req
);
    localparam int unsigned PULSE_CYCLES = CLK_MHZ * PULSE_US;

    hst_t d, q;

    logic       sel_cmd, wr_cmd, wr_dat, rd_dat;
    act_e       act;
    logic [3:0] pulse_sel;
    logic       pulse_busy;
    logic [3:0] pulse_low;
    logic [7:0] host_byte;
    logic       any_full, aux_only;
    logic [7:0] status_byte, outp_view;
    logic       pulse_start;

    assign sel_cmd = |(bus_addr & CMD_SEL_MASK);
    assign wr_cmd  = bus_en &  bus_we &  sel_cmd;
    assign wr_dat  = bus_en &  bus_we & ~sel_cmd;
    assign rd_dat  = bus_en & ~bus_we & ~sel_cmd;

    kbc_cmd_dec u_dec (
        .cmd_byte  (bus_wdata),
        .act       (act),
        .pulse_sel (pulse_sel)
    );

    assign pulse_start = wr_cmd && (act == ACT_PULSE);

    kbc_pulse_gen #(.CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pulse_start),
        .sel   (pulse_sel),
        .busy  (pulse_busy),
        .low   (pulse_low)
    );

    kbc_out_sel u_sel (
        .kbd_full  (q.kbd_full),
        .aux_full  (q.aux_full),
        .kbd_byte  (q.kbd_buf),
        .aux_byte  (q.aux_buf),
        .host_byte (host_byte),
        .any_full  (any_full),
        .aux_only  (aux_only)
    );

    assign status_byte = {2'b00, aux_only, 1'b1, q.cmd_flag, 2'b00, any_full};
    assign outp_view   = {q.outp[7:6], aux_only, any_full, q.outp[3:0]};

    always_comb begin
        logic       rsp_v;
        logic [7:0] rsp_b;
        d       = q;
        d.ktx_v = 1'b0;
        d.atx_v = 1'b0;
        rsp_v   = 1'b0;
        rsp_b   = 8'h00;

        // host read empties the slot it was served from
        if (rd_dat) begin
            if (q.kbd_full)      d.kbd_full = 1'b0;
            else if (q.aux_full) d.aux_full = 1'b0;
        end

        if (wr_cmd) begin
            d.cmd_flag = 1'b1;
            d.wt       = WAIT_NONE;
            case (act)
                ACT_RD_MODE: begin rsp_v = 1'b1; rsp_b = q.mode;    end
                ACT_RD_OUTP: begin rsp_v = 1'b1; rsp_b = outp_view; end
                ACT_WR_MODE: d.wt = WAIT_MODE;
                ACT_WR_OUTP: d.wt = WAIT_OUTP;
                ACT_WR_AUX:  d.wt = WAIT_AUX;
                ACT_A20_ON:  d.outp[1] = 1'b1;
                ACT_A20_OFF: d.outp[1] = 1'b0;
                default: ;
            endcase
        end

        if (wr_dat) begin
            d.cmd_flag = 1'b0;
            d.wt       = WAIT_NONE;
            case (q.wt)
                WAIT_MODE: d.mode = bus_wdata;
                WAIT_OUTP: d.outp = bus_wdata;
                WAIT_AUX:  begin d.atx_v = 1'b1; d.atx_b = bus_wdata; end
                default:   begin d.ktx_v = 1'b1; d.ktx_b = bus_wdata; end
            endcase
        end

        // controller response takes the keyboard slot outright
        if (rsp_v) begin
            d.kbd_buf  = rsp_b;
            d.kbd_full = 1'b1;
        end else if (kbd_rx_valid && !d.kbd_full) begin
            d.kbd_buf  = kbd_rx_byte;
            d.kbd_full = 1'b1;
        end

        if (aux_rx_valid && !d.aux_full) begin
            d.aux_buf  = aux_rx_byte;
            d.aux_full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= HST_RST;
        else        q <= d;
    end

    assign bus_rdata     = sel_cmd ? status_byte : host_byte;
    assign kbd_tx_valid  = q.ktx_v;
    assign kbd_tx_byte   = q.ktx_b;
    assign aux_tx_valid  = q.atx_v;
    assign aux_tx_byte   = q.atx_b;
    assign irq_kbd       = q.kbd_full & q.mode[0];
    assign irq_aux       = aux_only & q.mode[1];
    assign port_lines    = q.outp[3:0] & ~pulse_low;
    assign a20_gate      = port_lines[1];
    assign sys_reset_req = ~port_lines[0];
endmodule

// File: rtl/kbc_host_if_chk.sv
`timescale 1ns/1ps
module kbc_host_if_chk #(
    parameter int unsigned       ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] CMD_SEL_MASK = ADDR_W'(4),
    parameter int unsigned       PULSE_CYCLES = 1200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              a20_gate,
    input logic              irq_kbd,
    input logic              irq_aux,
    input logic              kbd_tx_valid,
    input logic              aux_tx_valid,
    input logic              pulse_busy
);
    logic c_sel, c_wr, d_wr;
    assign c_sel = (bus_addr & CMD_SEL_MASK) != '0;
    assign c_wr  = bus_en && bus_we && c_sel;
    assign d_wr  = bus_en && bus_we && !c_sel;

    int unsigned busy_run;
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_run <= 0;
        else if (pulse_busy) busy_run <= busy_run + 1;
        else                 busy_run <= 0;
    end

    // R7: a pulse never outlasts its window
    a_r7_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= PULSE_CYCLES);

    // R7: a pulse only begins after a pulse command
    a_r7_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_busy) |-> $past(c_wr && bus_wdata[7:4] == 4'hF));

    // R6: gate on unless a pulse holds it
    a_r6_a20_on: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && bus_wdata == 8'hDF) |=> (a20_gate || pulse_busy));

    // R6: gate off
    a_r6_a20_off: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && bus_wdata == 8'hDD) |=> !a20_gate);

    // R3: device bytes only follow a data-port write
    a_r3_tx_src: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_tx_valid || aux_tx_valid) |-> $past(d_wr));

    // R3: one destination per data write
    a_r3_tx_one: assert property (@(posedge clk) disable iff (!rst_n)
        !(kbd_tx_valid && aux_tx_valid));

    // R10: keyboard data masks the mouse interrupt
    a_r10_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_kbd && irq_aux));
endmodule

bind kbc_host_if kbc_host_if_chk #(
    .ADDR_W       (ADDR_W),
    .CMD_SEL_MASK (CMD_SEL_MASK),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_en       (bus_en),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .a20_gate     (a20_gate),
    .irq_kbd      (irq_kbd),
    .irq_aux      (irq_aux),
    .kbd_tx_valid (kbd_tx_valid),
    .aux_tx_valid (aux_tx_valid),
    .pulse_busy   (pulse_busy)
);

// File: tb/sim_kbc_host_if.sv
`timescale 1ns/1ps
module sim_kbc_host_if;
    localparam int PULSE_N = 1200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
    logic       kbd_rx_valid = 1'b0, aux_rx_valid = 1'b0;
    logic [7:0] kbd_rx_byte = 8'h00, aux_rx_byte = 8'h00;
    logic       kbd_tx_valid, aux_tx_valid;
    logic [7:0] kbd_tx_byte, aux_tx_byte;
    logic       irq_kbd, irq_aux, a20_gate, sys_reset_req;
    logic [3:0] port_lines;

    always #2.5 clk = ~clk;

    kbc_host_if u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_rx_valid(kbd_rx_valid), .kbd_rx_byte(kbd_rx_byte),
        .aux_rx_valid(aux_rx_valid), .aux_rx_byte(aux_rx_byte),
        .kbd_tx_valid(kbd_tx_valid), .kbd_tx_byte(kbd_tx_byte),
        .aux_tx_valid(aux_tx_valid), .aux_tx_byte(aux_tx_byte),
        .irq_kbd(irq_kbd), .irq_aux(irq_aux), .port_lines(port_lines),
        .a20_gate(a20_gate), .sys_reset_req(sys_reset_req)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;

    // bench model
    logic       mk_p = 0, ma_p = 0, mflag = 1;
    logic [7:0] mk_b = 0, ma_b = 0, mmode = 8'h03, mout = 8'h03;
    int         mwait = 0;
    logic       ktx_s, atx_s;
    logic [7:0] ktx_bs, atx_bs;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {2'b00, !mk_p && ma_p, 1'b1, mflag, 2'b00, mk_p || ma_p};
    endfunction

    function automatic logic [7:0] exp_view();
        return {mout[7:6], !mk_p && ma_p, mk_p || ma_p, mout[3:0]};
    endfunction

    task automatic bus_wr(input bit cmd, input logic [7:0] b);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_wdata = b;
        bus_addr = cmd ? (8'($urandom) | 8'h04) : (8'($urandom) & 8'hFB);
        @(negedge clk);
        ktx_s = kbd_tx_valid; ktx_bs = kbd_tx_byte;
        atx_s = aux_tx_valid; atx_bs = aux_tx_byte;
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input bit cmd, output logic [7:0] v);
        @(negedge clk);
        bus_en = 1; bus_we = 0;
        bus_addr = cmd ? (8'($urandom) | 8'h04) : (8'($urandom) & 8'hFB);
        #1 v = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic host_cmd(input logic [7:0] c);
        logic [7:0] view;
        view = exp_view();
        bus_wr(1, c);
        mflag = 1; mwait = 0;
        case (c)
            8'h20: begin mk_b = mmode; mk_p = 1; end
            8'hD0: begin mk_b = view;  mk_p = 1; end
            8'h60: mwait = 1;
            8'hD1: mwait = 2;
            8'hD4: mwait = 3;
            8'hDD: mout[1] = 0;
            8'hDF: mout[1] = 1;
            default: ;
        endcase
    endtask

    task automatic host_dat(input logic [7:0] b);
        bus_wr(0, b);
        mflag = 0;
        case (mwait)
            1: mmode = b;
            2: mout = b;
            3: begin chk("R3 aux tx", {atx_s, ktx_s, atx_bs}, {2'b10, b}); end
            default: chk("R3 kbd tx", {ktx_s, atx_s, ktx_bs}, {2'b10, b});
        endcase
        mwait = 0;
    endtask

    task automatic host_read(input string r);
        logic [7:0] v;
        bus_rd(0, v);
        if (mk_p) begin chk(r, v, mk_b); mk_p = 0; end
        else if (ma_p) begin chk(r, v, ma_b); ma_p = 0; end
    endtask

    task automatic host_stat(input string r);
        logic [7:0] v;
        bus_rd(1, v);
        chk(r, v, exp_status());
    endtask

    task automatic dev_kbd(input logic [7:0] b);
        @(negedge clk); kbd_rx_valid = 1; kbd_rx_byte = b;
        @(negedge clk); kbd_rx_valid = 0;
        if (!mk_p) begin mk_p = 1; mk_b = b; end
    endtask

    task automatic dev_aux(input logic [7:0] b);
        @(negedge clk); aux_rx_valid = 1; aux_rx_byte = b;
        @(negedge clk); aux_rx_valid = 0;
        if (!ma_p) begin ma_p = 1; ma_b = b; end
    endtask

    task automatic irq_chk();
        chk("R10 irq_kbd", irq_kbd, mk_p && mmode[0]);
        chk("R10 irq_aux", irq_aux, !mk_p && ma_p && mmode[1]);
    endtask

    task automatic run_pulse(output int n_rst, output int n_a20);
        int guard = 0;
        n_rst = 0; n_a20 = 0;
        while ((sys_reset_req || !a20_gate) && guard < 5000) begin
            if (sys_reset_req) n_rst++;
            if (!a20_gate)     n_a20++;
            guard++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nr, na;
        logic [7:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2 reset state
        host_stat("R2 status");
        chk("R2 a20", a20_gate, 1'b1);
        chk("R2 reset req", sys_reset_req, 1'b0);
        chk("R2 lines", port_lines, 4'h3);
        chk("R2 irqs", {irq_kbd, irq_aux}, 2'b00);
        host_cmd(8'h20);
        host_stat("R9 status after response");
        host_read("R2 mode after reset");

        // R1 explicit decode
        @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = 8'h04; #1 v = bus_rdata;
        @(negedge clk); bus_en = 0;
        chk("R1 status at 0x04", v, exp_status());
        @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = 8'hFB; bus_wdata = 8'h3C;
        @(negedge clk); chk("R1 data at 0xFB", {kbd_tx_valid, kbd_tx_byte}, {1'b1, 8'h3C});
        bus_en = 0; bus_we = 0; mflag = 0;

        // R3 routing
        host_dat(8'h5A);
        host_cmd(8'hD4); host_dat(8'h77);
        host_dat(8'h11);
        host_cmd(8'hD4); host_cmd(8'hAA); host_dat(8'h22);
        host_stat("R9 status after data write");

        // R4 / R10 mode and interrupt gating
        host_cmd(8'h60); host_dat(8'h00);
        host_cmd(8'h20); irq_chk(); host_read("R4 written mode");
        dev_kbd(8'h1C); irq_chk(); host_stat("R9 kbd full");
        host_read("R8 kbd byte");
        host_cmd(8'h60); host_dat(8'h03);
        dev_kbd(8'h2D); irq_chk();
        dev_aux(8'h08); irq_chk(); host_stat("R9 both full");
        host_read("R8 kbd first"); irq_chk(); host_stat("R9 aux only");
        host_read("R8 aux second"); irq_chk();

        // R11 drop when full, response wins
        dev_kbd(8'h41); dev_kbd(8'h42);
        host_read("R11 first kept"); host_stat("R11 second dropped");
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 8'h64; bus_wdata = 8'h20;
        kbd_rx_valid = 1; kbd_rx_byte = 8'h55;
        @(negedge clk);
        bus_en = 0; bus_we = 0; kbd_rx_valid = 0;
        mk_p = 1; mk_b = mmode; mflag = 1; mwait = 0;
        host_read("R11 response wins");
        host_stat("R11 slot empty");

        // R5 output port
        dev_aux(8'h99);
        host_cmd(8'hD0);
        host_read("R5 view with aux"); host_read("R5 aux after view");
        host_cmd(8'hD1); host_dat(8'h01);
        chk("R5 a20 low", a20_gate, 1'b0);
        chk("R5 lines", port_lines, 4'h1);
        host_cmd(8'hD0); host_read("R5 view stored");
        host_cmd(8'hD1); host_dat(8'h00);
        chk("R5 reset req", sys_reset_req, 1'b1);
        host_cmd(8'hD1); host_dat(8'h03);
        chk("R5 reset released", sys_reset_req, 1'b0);

        // R6 A20 commands
        host_cmd(8'hDD); chk("R6 a20 off", a20_gate, 1'b0);
        host_cmd(8'hDF); chk("R6 a20 on", a20_gate, 1'b1);
        host_cmd(8'hD0); host_read("R6 view after on");

        // R7 pulses
        host_cmd(8'hFE);
        chk("R7 reset pulsed", sys_reset_req, 1'b1);
        host_cmd(8'hFD);
        run_pulse(nr, na);
        chk("R7 FE length rest", nr, PULSE_N - 2);
        chk("R7 busy ignores FD", na, 0);
        host_cmd(8'hFD);
        run_pulse(nr, na);
        chk("R7 FD a20 length", na, PULSE_N);
        chk("R7 FD no reset", nr, 0);
        host_cmd(8'hF0);
        chk("R7 F0 all low", port_lines, 4'h0);
        run_pulse(nr, na);
        chk("R7 F0 length", {nr[15:0], na[15:0]}, {16'(PULSE_N), 16'(PULSE_N)});
        host_cmd(8'hFF);
        repeat (3) @(negedge clk);
        chk("R7 FF no-op", {port_lines, sys_reset_req}, {4'h3, 1'b0});

        // random mix, R8 R9 R10 R11
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 6);
            case (op)
                0: dev_kbd(8'($urandom));
                1: dev_aux(8'($urandom));
                2, 3: host_read("R8 random read");
                4: host_stat("R9 random status");
                5: host_cmd(8'h20);
                default: host_cmd(8'hD0);
            endcase
            if (op == 4) irq_chk();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule